// File: doc/BRIEF.md
# Character Display Nibble-Bus Write Controller

This block drives a character display module that is wired with a four-bit data bus plus register-select, read/write and enable strobes. Right after reset it runs the display's power-up routine on its own: a long settling wait, three "8-bit mode" nibbles and one "4-bit mode" nibble, each followed by its own wait. It then writes a fixed set of configuration commands: two lines on the narrow bus, display off, clear, cursor auto-increment, display on with the cursor hidden, and a final clear.

Once that routine is done, the block takes byte requests on a ready/valid port. Each request carries an 8-bit value and a flag that marks it as display data or as a command. The block splits each byte into two nibbles, high nibble first. For each nibble it raises the enable line with the nibble and the register-select level on the pins, and lowers enable to latch. It then waits a settle time before doing anything else. A clear or home command waits much longer after its second nibble. The read/write line is held at write, and the block never polls the busy flag.

All waits are counted in ticks of a one-microsecond enable input by a single down-counter that is reloaded at every step. Every wait length is a parameter.

Top module: `lcd4_ctrl`

## Requirements
- R1: After reset the block waits PWRUP_US ticks. It then sends the single nibbles 0x3, 0x3, 0x3, 0x2 with RS=0. The waits after them are INIT_LONG_US, INIT_SHORT_US, NIBBLE_US and NIBBLE_US ticks.
- R2: The single nibbles are followed by the command bytes 0x28, 0x08, 0x01, 0x06, 0x0C, 0x01 in that order, all with RS=0.
- R3: Every byte goes out as two nibbles, bits 7:4 first and then bits 3:0. The wait after each nibble is NIBBLE_US ticks, except for the case in R4.
- R4: After the second nibble of a command (RS=0) whose value is 0x01 or 0x02, the wait is CLRHOME_US ticks. Any other byte gets the normal wait, including data value 0x01 sent with RS=1.
- R5: During each nibble, RS equals the request's flag (1 = data, 0 = command). RW is always 0.
- R6: EN stays high for EN_US to EN_US+1 ticks. DB and RS change only when EN rises, so both are stable while EN is high and across its falling edge.
- R7: req_ready stays low during the power-up routine and during every post-nibble wait. A request offered while req_ready is low is ignored and produces no nibble.
- R8: Waits advance only on clock cycles where tick_us is high. A wait of N ticks lasts N to N+1 ticks.
- R9: While reset is held, EN, RS, DB and req_ready are all 0. Releasing reset restarts the routine from R1, even if reset cut a byte short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-microsecond tick enable for all waits |
| req_valid | input | 1 | Byte request offered |
| req_ready | output | 1 | Block can take a byte this cycle |
| req_data | input | 8 | Byte to write |
| req_rs | input | 1 | 1 = display data, 0 = command |
| lcd_rs | output | 1 | Register-select pin |
| lcd_rw | output | 1 | Read/write pin, always 0 |
| lcd_en | output | 1 | Enable strobe, data latched on its fall |
| lcd_db | output | 4 | Data bus, bits 7..4 of the display |

## Verification
The bench shrinks every wait to a few ticks: power-up 40, first init wait 20, second init wait 10, nibble wait 5, clear/home wait 25, and enable 2. It drives tick_us on every second clock. With these values the whole power-up routine and a table of requests fit in a few thousand cycles. The five wait lengths are distinct, so the bench can measure each gap in ticks and tell which wait was chosen. The bench also checks that the tick gating doubles the wall-clock length of each wait. The table includes home, clear, a data byte equal to the clear code, and a command byte that needs a short wait, so the bench covers both sides of the long-wait decision.

// File: rtl/lcd4_pkg.sv
// Shared types and constants for the nibble-bus display controller.
// Assumes the fixed power-up routine of four single nibbles and six
// configuration bytes.
package lcd4_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,   // initial settling wait
        ST_EN_HI,   // enable high, nibble on the bus
        ST_HOLD,    // post-nibble settle wait
        ST_IDLE     // ready for a request
    } lcd4_state_t;

    localparam int INIT_STEPS = 10;
    localparam int INIT_IDX_W = $clog2(INIT_STEPS);
    localparam int SINGLE_STEPS = 4;

    // Larger of two integers, used to size the delay counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Power-up routine item: {single-nibble flag, value}.
    function automatic logic [8:0] init_item(input logic [INIT_IDX_W-1:0] idx);
        case (idx)
            4'd0, 4'd1, 4'd2: init_item = {1'b1, 8'h03};
            4'd3:             init_item = {1'b1, 8'h02};
            4'd4:             init_item = {1'b0, 8'h28};
            4'd5:             init_item = {1'b0, 8'h08};
            4'd6:             init_item = {1'b0, 8'h01};
            4'd7:             init_item = {1'b0, 8'h06};
            4'd8:             init_item = {1'b0, 8'h0C};
            default:          init_item = {1'b0, 8'h01};
        endcase
    endfunction

endpackage

// File: rtl/lcd4_delay.sv
// Single tick-gated down-counter shared by every wait of the controller.
// A load sets the count; each cycle with tick high lowers it by one; done
// is high while the count is zero. Assumes load values fit in W bits.
module lcd4_delay #(
    parameter int W       = 15,
    parameter int RST_VAL = 20000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Reload on request, otherwise count down on ticks until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !load |=> done); // R8
    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load |=> $stable(cnt)); // R8

endmodule

// File: rtl/lcd4_wait_sel.sv
// Picks the settle wait that follows the nibble now being strobed.
// Power-up single nibbles use their staged waits; a command clear or home
// gets the long wait after its low nibble; all else the nibble wait.
module lcd4_wait_sel
    import lcd4_pkg::*;
#(
    parameter int W             = 15,
    parameter int INIT_LONG_US  = 4100,
    parameter int INIT_SHORT_US = 100,
    parameter int NIBBLE_US     = 40,
    parameter int CLRHOME_US    = 2000
) (
    input  logic                  single,
    input  logic [INIT_IDX_W-1:0] init_idx,
    input  logic                  phase_hi,
    input  logic [7:0]            byte_val,
    input  logic                  rs,
    output logic [W-1:0]          post_wait
);

    logic slow_cmd;

    // Clear (0x01) and home (0x02) commands need the long wait.
    assign slow_cmd = !rs && (byte_val == 8'h01 || byte_val == 8'h02);

    // Choose the wait length for the current nibble.
    always_comb begin
        if (single) begin
            case (init_idx)
                4'd0:    post_wait = W'(INIT_LONG_US);
                4'd1:    post_wait = W'(INIT_SHORT_US);
                default: post_wait = W'(NIBBLE_US);
            endcase
        end else if (!phase_hi && slow_cmd) begin
            post_wait = W'(CLRHOME_US);
        end else begin
            post_wait = W'(NIBBLE_US);
        end
    end

endmodule

// File: rtl/lcd4_ctrl.sv
// Nibble-bus character display write controller (top).
// Runs the power-up routine, then writes requested bytes as two nibbles
// with per-nibble settle waits. Assumes tick_us pulses once per microsecond
// and EN_US >= 1. Never reads the display.
module lcd4_ctrl
    import lcd4_pkg::*;
#(
    parameter int PWRUP_US      = 20000,
    parameter int INIT_LONG_US  = 4100,
    parameter int INIT_SHORT_US = 100,
    parameter int NIBBLE_US     = 40,
    parameter int CLRHOME_US    = 2000,
    parameter int EN_US         = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [7:0] req_data,
    input  logic       req_rs,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [3:0] lcd_db
);

    localparam int MAX_WAIT = max2(max2(max2(PWRUP_US, INIT_LONG_US), max2(INIT_SHORT_US, NIBBLE_US)),
                                   max2(CLRHOME_US, EN_US));
    localparam int CNT_W = $clog2(MAX_WAIT + 1);
    localparam logic [INIT_IDX_W-1:0] INIT_LAST = INIT_IDX_W'(INIT_STEPS - 1);

    lcd4_state_t           state;
    logic [7:0]            cur_byte;
    logic                  cur_rs;
    logic                  cur_single;
    logic                  phase_hi;
    logic                  in_init;
    logic [INIT_IDX_W-1:0] init_idx;
    logic                  en_q;
    logic                  rs_q;
    logic [3:0]            db_q;

    logic                  dly_load;
    logic [CNT_W-1:0]      dly_val;
    logic                  dly_done;
    logic [CNT_W-1:0]      post_wait;

    logic                  start_go;
    logic [7:0]            start_byte;
    logic                  start_rs;
    logic                  start_single;
    logic                  hold_next_lo;
    logic                  hold_next_init;
    logic [8:0]            item_first;
    logic [8:0]            item_next;

    assign item_first = init_item('0);
    assign item_next  = init_item(init_idx + 1'b1);

    lcd4_delay #(
        .W       (CNT_W),
        .RST_VAL (PWRUP_US)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (dly_load),
        .load_val (dly_val),
        .done     (dly_done)
    );

    lcd4_wait_sel #(
        .W             (CNT_W),
        .INIT_LONG_US  (INIT_LONG_US),
        .INIT_SHORT_US (INIT_SHORT_US),
        .NIBBLE_US     (NIBBLE_US),
        .CLRHOME_US    (CLRHOME_US)
    ) u_wait_sel (
        .single    (cur_single),
        .init_idx  (init_idx),
        .phase_hi  (phase_hi),
        .byte_val  (cur_byte),
        .rs        (cur_rs),
        .post_wait (post_wait)
    );

    // Decide whether a new item starts this cycle and where it comes from.
    always_comb begin
        hold_next_lo   = (state == ST_HOLD) && dly_done && !cur_single && phase_hi;
        hold_next_init = (state == ST_HOLD) && dly_done && !hold_next_lo &&
                         in_init && (init_idx != INIT_LAST);
        start_go     = 1'b0;
        start_byte   = item_first[7:0];
        start_rs     = 1'b0;
        start_single = item_first[8];
        if (state == ST_PWRUP && dly_done) begin
            start_go = 1'b1;
        end else if (hold_next_init) begin
            start_go     = 1'b1;
            start_byte   = item_next[7:0];
            start_single = item_next[8];
        end else if (state == ST_IDLE && req_valid) begin
            start_go     = 1'b1;
            start_byte   = req_data;
            start_rs     = req_rs;
            start_single = 1'b0;
        end
    end

    // Delay counter reload: enable width on each rise, settle wait on each fall.
    always_comb begin
        dly_load = 1'b0;
        dly_val  = CNT_W'(EN_US);
        if (start_go || hold_next_lo) begin
            dly_load = 1'b1;
        end else if (state == ST_EN_HI && dly_done) begin
            dly_load = 1'b1;
            dly_val  = post_wait;
        end
    end

    // Sequencer: item start, nibble strobe, settle wait, routine stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PWRUP;
            cur_byte   <= '0;
            cur_rs     <= 1'b0;
            cur_single <= 1'b0;
            phase_hi   <= 1'b1;
            in_init    <= 1'b1;
            init_idx   <= '0;
            en_q       <= 1'b0;
            rs_q       <= 1'b0;
            db_q       <= '0;
        end else if (start_go) begin
            if (hold_next_init)
                init_idx <= init_idx + 1'b1;
            cur_byte   <= start_byte;
            cur_rs     <= start_rs;
            cur_single <= start_single;
            phase_hi   <= 1'b1;
            rs_q       <= start_rs;
            db_q       <= start_single ? start_byte[3:0] : start_byte[7:4];
            en_q       <= 1'b1;
            state      <= ST_EN_HI;
        end else if (hold_next_lo) begin
            phase_hi <= 1'b0;
            db_q     <= cur_byte[3:0];
            en_q     <= 1'b1;
            state    <= ST_EN_HI;
        end else if (state == ST_EN_HI && dly_done) begin
            en_q  <= 1'b0;
            state <= ST_HOLD;
        end else if (state == ST_HOLD && dly_done) begin
            in_init <= 1'b0;
            state   <= ST_IDLE;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign lcd_en    = en_q;
    assign lcd_rs    = rs_q;
    assign lcd_db    = db_q;
    assign lcd_rw    = 1'b0;

    AST_FALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_BUS_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6
    AST_EN_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |=> lcd_en); // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_en); // R7
    AST_ACCEPT_HIGH_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> lcd_en && lcd_db == $past(req_data[7:4]) &&
                                   lcd_rs == $past(req_rs)); // R3 R5

endmodule

// File: tb/lcd4_ctrl_bench.sv
// Bench: logs every strobed nibble with the tick counts around it, then
// compares against a sequence built from the requirements.
module lcd4_ctrl_bench;

    localparam int P_PWR = 40;
    localparam int P_IL  = 20;
    localparam int P_IS  = 10;
    localparam int P_NIB = 5;
    localparam int P_CLR = 25;
    localparam int P_EN  = 2;
    localparam int NREQ  = 6;
    localparam int NINIT = 16;
    localparam int NTOT  = NINIT + 2 * NREQ;

    // Request table: {rs, data}
    localparam logic [8:0] REQS [NREQ] = '{9'h141, 9'h002, 9'h17A, 9'h001, 9'h080, 9'h101};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_data = '0;
    logic       req_rs = 1'b0;
    logic       lcd_rs, lcd_rw, lcd_en;
    logic [3:0] lcd_db;

    int errors = 0;
    int checks = 0;

    lcd4_ctrl #(
        .PWRUP_US(P_PWR), .INIT_LONG_US(P_IL), .INIT_SHORT_US(P_IS),
        .NIBBLE_US(P_NIB), .CLRHOME_US(P_CLR), .EN_US(P_EN)
    ) u_lcd4_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
        .req_ready(req_ready), .req_data(req_data), .req_rs(req_rs),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_db(lcd_db)
    );

    always #2.5 clk = ~clk;

    // Tick every second clock, changed away from the active edge.
    always @(negedge clk) tick_us <= ~tick_us;

    // Log of observed nibbles
    logic [3:0] log_nib [64];
    logic       log_rs  [64];
    int         log_gap [64];
    int         log_hi  [64];
    int         n_log = 0;
    int         lo_ticks = 0;
    int         hi_ticks = 0;
    logic       prev_en = 1'b0;
    logic       rw_bad = 1'b0;
    logic       ready_early = 1'b0;
    logic       moved_in_hi = 1'b0;
    logic [4:0] hi_bus;
    int         cyc = 0;
    int         first_rise_cyc = -1;
    int         rel_cyc = 0;

    // Expected sequence
    logic [3:0] e_nib [64];
    logic       e_rs  [64];
    int         e_gap [64];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int byte_wait(input logic [7:0] b, input logic rs);
        return (!rs && (b == 8'h01 || b == 8'h02)) ? P_CLR : P_NIB;
    endfunction

    // Monitor at the falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_en  <= 1'b0;
            lo_ticks = 0;
            hi_ticks = 0;
            rel_cyc  = cyc;
        end else begin
            if (lcd_rw !== 1'b0) rw_bad <= 1'b1;
            if (req_ready && n_log < NINIT) ready_early <= 1'b1;
            if (lcd_en && !prev_en) begin
                if (n_log < 64) log_gap[n_log] = lo_ticks;
                if (first_rise_cyc < 0) first_rise_cyc = cyc - rel_cyc;
                hi_bus = {lcd_rs, lcd_db};
                hi_ticks = 0;
            end
            if (lcd_en && prev_en && {lcd_rs, lcd_db} != hi_bus) moved_in_hi <= 1'b1;
            if (!lcd_en && prev_en) begin
                if (n_log < 64) begin
                    log_nib[n_log] = lcd_db;
                    log_rs[n_log]  = lcd_rs;
                    log_hi[n_log]  = hi_ticks;
                end
                n_log++;
                lo_ticks = 0;
            end
            if (tick_us) begin
                if (lcd_en) hi_ticks++;
                else lo_ticks++;
            end
            prev_en <= lcd_en;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k;
        int base;
        // Build expected sequence (R1 R2 R3 R4)
        e_nib[0] = 4'h3; e_nib[1] = 4'h3; e_nib[2] = 4'h3; e_nib[3] = 4'h2;
        e_gap[0] = P_PWR; e_gap[1] = P_IL; e_gap[2] = P_IS; e_gap[3] = P_NIB;
        for (int i = 0; i < 4; i++) e_rs[i] = 1'b0;
        k = 4;
        begin
            logic [7:0] cfg [6];
            logic [3:0] prev_w;
            int last_w;
            cfg = '{8'h28, 8'h08, 8'h01, 8'h06, 8'h0C, 8'h01};
            last_w = P_NIB;
            prev_w = '0;
            for (int i = 0; i < 6; i++) begin
                e_nib[k] = cfg[i][7:4]; e_rs[k] = 1'b0; e_gap[k] = last_w; k++;
                e_nib[k] = cfg[i][3:0]; e_rs[k] = 1'b0; e_gap[k] = P_NIB; k++;
                last_w = byte_wait(cfg[i], 1'b0);
            end
            for (int i = 0; i < NREQ; i++) begin
                e_nib[k] = REQS[i][7:4]; e_rs[k] = REQS[i][8]; e_gap[k] = last_w; k++;
                e_nib[k] = REQS[i][3:0]; e_rs[k] = REQS[i][8]; e_gap[k] = P_NIB; k++;
                last_w = byte_wait(REQS[i][7:0], REQS[i][8]);
            end
            prev_w = 4'(last_w);
        end

        // Reset state (R9)
        repeat (4) @(negedge clk);
        check(lcd_en == 1'b0 && lcd_rs == 1'b0, "R9 en/rs in reset", {lcd_en, lcd_rs}, 0);
        check(lcd_db == 4'h0, "R9 db in reset", lcd_db, 0);
        check(req_ready == 1'b0, "R9 ready in reset", req_ready, 0);
        check(lcd_rw == 1'b0, "R5 rw in reset", lcd_rw, 0);
        rst_n = 1'b1;

        // Requests offered during power-up must be ignored (R7)
        req_valid = 1'b1; req_data = 8'hFF; req_rs = 1'b1;
        repeat (30) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R7 ready low in power-up", req_ready, 0);
        end
        req_valid = 1'b0; req_data = 8'h00; req_rs = 1'b0;

        // Walk the request table
        for (int i = 0; i < NREQ; i++) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1; req_data = REQS[i][7:0]; req_rs = REQS[i][8];
            @(negedge clk);
            req_valid = 1'b0;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (10) @(negedge clk);

        check(n_log == NTOT, "R7 nibble count (ignored requests)", n_log, NTOT);
        check(!ready_early, "R7 ready during power-up", ready_early, 0);
        check(!rw_bad, "R5 rw held low", rw_bad, 0);
        check(!moved_in_hi, "R6 bus stable while EN high", moved_in_hi, 0);
        check(first_rise_cyc >= 2 * P_PWR, "R8 tick gating of first wait", first_rise_cyc, 2 * P_PWR);
        for (int i = 0; i < NTOT && i < n_log; i++) begin
            check(log_nib[i] == e_nib[i], (i < 4) ? "R1 init nibble" : (i < NINIT) ? "R2 config nibble" : "R3 request nibble",
                  log_nib[i], e_nib[i]);
            check(log_rs[i] == e_rs[i], "R5 rs level", log_rs[i], e_rs[i]);
            check(log_gap[i] >= e_gap[i] && log_gap[i] <= e_gap[i] + 3,
                  (e_gap[i] == P_CLR) ? "R4 long wait" : "R8 wait length", log_gap[i], e_gap[i]);
            check(log_hi[i] >= P_EN && log_hi[i] <= P_EN + 1, "R6 EN width", log_hi[i], P_EN);
        end

        // Reset in the middle of a byte restarts the routine (R9)
        @(negedge clk);
        req_valid = 1'b1; req_data = 8'h55; req_rs = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(lcd_en == 1'b1, "R3 new byte strobing", lcd_en, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(lcd_en == 1'b0 && lcd_rs == 1'b0 && lcd_db == 4'h0, "R9 outputs cleared",
              {lcd_en, lcd_rs, lcd_db}, 0);
        check(req_ready == 1'b0, "R9 ready cleared", req_ready, 0);
        base = n_log;
        rst_n = 1'b1;
        while (n_log == base) @(negedge clk);
        check(log_nib[base] == 4'h3 && log_rs[base] == 1'b0, "R9 restart nibble",
              log_nib[base], 3);
        check(log_gap[base] >= P_PWR && log_gap[base] <= P_PWR + 3, "R9 restart wait",
              log_gap[base], P_PWR);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule